// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register file of a 32-bit processor core. Software sees sixteen registers, addressed by a 4-bit index. Behind them sit thirty stored physical words. The program counter is the sixteenth register; it is not stored here and is supplied by the fetch stage. The operating mode on the `mode_i` input selects which physical word each index reaches. The low indices are common to every mode. The middle indices have a private copy for the fast-interrupt mode. The stack-pointer and link-register indices have one copy for each exception mode, and one further copy that user and system mode share.

The block has two combinational read ports and one write port. The write takes effect on the clock edge. It also holds the current status word and a saved status word for each of the five exception modes. When the core takes an exception, it raises a one-cycle entry strobe with the target mode and a return address. On that edge the block copies the current status word into the target mode's saved status slot and places the return address in the target mode's link register. A write to the program-counter index is not stored. It leaves the block as a branch request, registered for one cycle.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears every stored register to zero, sets the status word to 0x000000D3, clears every saved status slot and deasserts `br_valid_o`.
- R2: Indices 0 to 7 select the same physical register in every mode, so a value written in one mode reads back unchanged in all the others.
- R3: Indices 8 to 12 have two copies: one used only in fast-interrupt mode and one shared by every other mode.
- R4: Indices 13 (stack pointer) and 14 (link register) have six copies. User and system mode share one, and fast-interrupt, interrupt, supervisor, abort and undefined mode each have their own.
- R5: A read of index 15 on either port returns `pc_i` plus 8.
- R6: A write to index 15 changes no stored register. In the following cycle `br_valid_o` is high for exactly one cycle, with `br_target_o` equal to the written data.
- R7: A read of a register that is being written in the same cycle returns the old value. The new value appears from the next cycle on.
- R8: Mode codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other code raises `mode_err_o` and behaves as user mode.
- R9: When `exc_en_i` is high, the edge stores the current status word (its value before that edge) into the saved slot of `exc_mode_i`, and stores `exc_ret_i` into that mode's link register. The link-register store wins over a normal write to the same physical register in that cycle. The saved-slot store wins over `sv_we_i` to the same slot.
- R10: In user mode, system mode or an invalid mode, a saved-status access (`sv_rd_i` or `sv_we_i` high) raises `sv_err_o`. In these modes `sv_rdata_o` reads zero and the write is dropped. In the exception modes, `sv_rdata_o` shows the current mode's saved slot and `sv_we_i` writes it.
- R11: When `stat_we_i` is high, `stat_o` shows `stat_wdata_i` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current operating mode code |
| mode_err_o | output | 1 | Mode code is not one of the seven legal codes |
| ra_idx_i | input | 4 | Read port A index |
| ra_data_o | output | 32 | Read port A data |
| rb_idx_i | input | 4 | Read port B index |
| rb_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write index |
| wr_data_i | input | 32 | Write data |
| pc_i | input | 32 | Address of the current instruction |
| br_valid_o | output | 1 | Branch request, one cycle after a write to index 15 |
| br_target_o | output | 32 | Branch target address |
| stat_we_i | input | 1 | Status word write enable |
| stat_wdata_i | input | 32 | Status word write data |
| stat_o | output | 32 | Current status word |
| sv_rd_i | input | 1 | Saved status read request |
| sv_we_i | input | 1 | Saved status write enable |
| sv_wdata_i | input | 32 | Saved status write data |
| sv_rdata_o | output | 32 | Saved status of the current mode, or zero |
| sv_err_o | output | 1 | Saved status accessed in a mode without one |
| exc_en_i | input | 1 | Exception entry strobe |
| exc_mode_i | input | 5 | Mode being entered |
| exc_ret_i | input | 32 | Return address for the link register |

## Verification
The bench tracks each bank of the reference model separately and switches modes between a write and the reads that follow. A design that decoded the mode wrongly would show a value written in one mode appearing in a mode that has its own copy, or a shared low register reading differently after a mode change. A read of the same index in the same cycle as the write catches a design that forwards the new value. An exception entry that is combined with a write to the same link register, or with a write to the same saved slot, catches reversed priority, because the normal write would then survive. Saved-status accesses in user mode, in system mode and with an illegal mode code check that the data is zero and that the slots of the other modes do not change.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  typedef logic [2:0] bank_t;
  localparam bank_t BANK_USR = 3'd0;
  localparam bank_t BANK_FIQ = 3'd1;
  localparam bank_t BANK_IRQ = 3'd2;
  localparam bank_t BANK_SVC = 3'd3;
  localparam bank_t BANK_ABT = 3'd4;
  localparam bank_t BANK_UND = 3'd5;

  localparam int NUM_BANKS = 6;
  localparam int NUM_SAVED = NUM_BANKS - 1;
  localparam int N_LOW     = 8;
  localparam int N_HI      = 5;
  localparam int HI_BASE   = N_LOW + 2 * N_HI;
  localparam int N_PHYS    = HI_BASE + 2 * NUM_BANKS;
  localparam int PHYS_W    = $clog2(N_PHYS);

  function automatic logic [PHYS_W-1:0] phys_of(bank_t b, logic [3:0] idx);
    logic [PHYS_W-1:0] r;
    if (idx < 4'd8)
      r = PHYS_W'(idx);
    else if (idx < 4'd13)
      r = (b == BANK_FIQ) ? PHYS_W'(idx) + PHYS_W'(N_HI) : PHYS_W'(idx);
    else
      r = PHYS_W'(HI_BASE) + PHYS_W'({b, 1'b0}) + PHYS_W'(idx == 4'd14);
    return r;
  endfunction
endpackage

// File: rtl/mode_decode.sv
module mode_decode
  import bank_pkg::*;
(
  input  logic [4:0] mode_i,
  output bank_t      bank_o,
  output logic       invalid_o,
  output logic       has_sv_o
);
  always_comb begin
    invalid_o = 1'b0;
    unique case (mode_i)
      M_USR, M_SYS: bank_o = BANK_USR;
      M_FIQ:        bank_o = BANK_FIQ;
      M_IRQ:        bank_o = BANK_IRQ;
      M_SVC:        bank_o = BANK_SVC;
      M_ABT:        bank_o = BANK_ABT;
      M_UND:        bank_o = BANK_UND;
      default: begin
        bank_o    = BANK_USR;
        invalid_o = 1'b1;
      end
    endcase
    has_sv_o = (bank_o != BANK_USR);
  end

  // R8: an illegal code falls back to the user bank with no saved slot
  always_comb begin
    if (!$isunknown(mode_i) && invalid_o)
      p_bad_mode_user_r8: assert (bank_o == BANK_USR && !has_sv_o);
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int DW   = 32,
  parameter int NREG = 30,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          xe,
  input  logic [AW-1:0] xaddr,
  input  logic [DW-1:0] xdata
);
  logic [DW-1:0] regs [NREG];

  // The exception write comes last, so it wins on a shared address.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (we) regs[waddr] <= wdata;
      if (xe) regs[xaddr] <= xdata;
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];

  // R9: the link-register store from an exception entry always lands
  p_exc_wins_r9: assert property (@(posedge clk) disable iff (rst)
    xe |=> regs[$past(xaddr)] == $past(xdata));
  // R7: a plain write shows up in the next cycle when nothing else hits it
  p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
    (we && !(xe && xaddr == waddr)) |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/psr_bank.sv
module psr_bank #(
  parameter int          DW      = 32,
  parameter int          NSAVED  = 5,
  parameter logic [31:0] RST_VAL = 32'h0000_00D3,
  localparam int         SW      = $clog2(NSAVED)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cur_we,
  input  logic [DW-1:0] cur_wdata,
  output logic [DW-1:0] cur_o,
  input  logic [SW-1:0] sv_slot,
  output logic [DW-1:0] sv_rdata,
  input  logic          sv_we,
  input  logic [DW-1:0] sv_wdata,
  input  logic          xe,
  input  logic [SW-1:0] x_slot
);
  logic [DW-1:0] cur_q;
  logic [DW-1:0] saved [NSAVED];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= DW'(RST_VAL);
      for (int i = 0; i < NSAVED; i++) saved[i] <= '0;
    end else begin
      if (cur_we) cur_q <= cur_wdata;
      if (sv_we)  saved[sv_slot] <= sv_wdata;
      if (xe)     saved[x_slot]  <= cur_q;
    end
  end

  assign cur_o    = cur_q;
  assign sv_rdata = saved[sv_slot];

  // R11: a status write is visible one cycle later
  p_status_wr_r11: assert property (@(posedge clk) disable iff (rst)
    cur_we |=> cur_q == $past(cur_wdata));
  // R9: exception entry saves the status word as it was before the edge
  p_exc_save_r9: assert property (@(posedge clk) disable iff (rst)
    xe |=> saved[$past(x_slot)] == $past(cur_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          PC_OFFSET  = 8,
  parameter logic [31:0] STATUS_RST = 32'h0000_00D3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    mode_i,
  output logic          mode_err_o,
  input  logic [3:0]    ra_idx_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [3:0]    rb_idx_i,
  output logic [DW-1:0] rb_data_o,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] pc_i,
  output logic          br_valid_o,
  output logic [DW-1:0] br_target_o,
  input  logic          stat_we_i,
  input  logic [DW-1:0] stat_wdata_i,
  output logic [DW-1:0] stat_o,
  input  logic          sv_rd_i,
  input  logic          sv_we_i,
  input  logic [DW-1:0] sv_wdata_i,
  output logic [DW-1:0] sv_rdata_o,
  output logic          sv_err_o,
  input  logic          exc_en_i,
  input  logic [4:0]    exc_mode_i,
  input  logic [DW-1:0] exc_ret_i
);
  localparam int SW = $clog2(NUM_SAVED);
  localparam logic [3:0] PC_IDX = 4'd15;
  localparam logic [3:0] LR_IDX = 4'd14;

  bank_t cur_bank, exc_bank;
  logic  cur_has_sv, exc_has_sv, exc_bad;

  mode_decode u_cur_mode (
    .mode_i(mode_i), .bank_o(cur_bank), .invalid_o(mode_err_o), .has_sv_o(cur_has_sv)
  );
  mode_decode u_exc_mode (
    .mode_i(exc_mode_i), .bank_o(exc_bank), .invalid_o(exc_bad), .has_sv_o(exc_has_sv)
  );

  logic [PHYS_W-1:0] ra_phys, rb_phys, wr_phys, lr_phys;
  logic [DW-1:0]     ra_raw, rb_raw;
  logic              gpr_we;

  assign ra_phys = phys_of(cur_bank, ra_idx_i);
  assign rb_phys = phys_of(cur_bank, rb_idx_i);
  assign wr_phys = phys_of(cur_bank, wr_idx_i);
  assign lr_phys = phys_of(exc_bank, LR_IDX);
  assign gpr_we  = wr_en_i && (wr_idx_i != PC_IDX);

  gpr_bank #(.DW(DW), .NREG(N_PHYS)) u_gpr (
    .clk(clk), .rst(rst),
    .ra_addr(ra_phys), .ra_data(ra_raw),
    .rb_addr(rb_phys), .rb_data(rb_raw),
    .we(gpr_we), .waddr(wr_phys), .wdata(wr_data_i),
    .xe(exc_en_i), .xaddr(lr_phys), .xdata(exc_ret_i)
  );

  assign ra_data_o = (ra_idx_i == PC_IDX) ? pc_i + DW'(PC_OFFSET) : ra_raw;
  assign rb_data_o = (rb_idx_i == PC_IDX) ? pc_i + DW'(PC_OFFSET) : rb_raw;

  // Saved status: bank n (n >= 1) owns slot n-1.
  logic [SW-1:0] cur_slot, exc_slot;
  logic [DW-1:0] sv_raw;
  logic          sv_we_ok, exc_sv_we;

  assign cur_slot  = cur_has_sv ? SW'(cur_bank - 3'd1) : '0;
  assign exc_slot  = exc_has_sv ? SW'(exc_bank - 3'd1) : '0;
  assign sv_we_ok  = sv_we_i && cur_has_sv;
  assign exc_sv_we = exc_en_i && exc_has_sv && !exc_bad;

  psr_bank #(.DW(DW), .NSAVED(NUM_SAVED), .RST_VAL(STATUS_RST)) u_psr (
    .clk(clk), .rst(rst),
    .cur_we(stat_we_i), .cur_wdata(stat_wdata_i), .cur_o(stat_o),
    .sv_slot(cur_slot), .sv_rdata(sv_raw),
    .sv_we(sv_we_ok), .sv_wdata(sv_wdata_i),
    .xe(exc_sv_we), .x_slot(exc_slot)
  );

  assign sv_rdata_o = cur_has_sv ? sv_raw : '0;
  assign sv_err_o   = (sv_rd_i || sv_we_i) && !cur_has_sv;

  // Writes to the program-counter index leave as a registered branch request.
  always_ff @(posedge clk) begin
    if (rst) begin
      br_valid_o  <= 1'b0;
      br_target_o <= '0;
    end else begin
      br_valid_o <= wr_en_i && (wr_idx_i == PC_IDX);
      if (wr_en_i && (wr_idx_i == PC_IDX)) br_target_o <= wr_data_i;
    end
  end

  // R6: a write to index 15 becomes a one-cycle branch request
  p_br_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_idx_i == PC_IDX) |=> (br_valid_o && br_target_o == $past(wr_data_i)));
  // R6: no branch request without a write to index 15
  p_br_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && wr_idx_i == PC_IDX) |=> !br_valid_o);
  // R10: a rejected saved-status access reads as zero
  p_sv_zero_r10: assert property (@(posedge clk) disable iff (rst)
    sv_err_o |-> sv_rdata_o == '0);
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode_i = 5'b10000;
  logic        mode_err_o;
  logic [3:0]  ra_idx_i = '0, rb_idx_i = '0, wr_idx_i = '0;
  logic [31:0] ra_data_o, rb_data_o;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0, pc_i = '0;
  logic        br_valid_o;
  logic [31:0] br_target_o;
  logic        stat_we_i = 1'b0;
  logic [31:0] stat_wdata_i = '0, stat_o;
  logic        sv_rd_i = 1'b0, sv_we_i = 1'b0;
  logic [31:0] sv_wdata_i = '0, sv_rdata_o;
  logic        sv_err_o;
  logic        exc_en_i = 1'b0;
  logic [4:0]  exc_mode_i = 5'b10000;
  logic [31:0] exc_ret_i = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .mode_err_o(mode_err_o),
    .ra_idx_i(ra_idx_i), .ra_data_o(ra_data_o), .rb_idx_i(rb_idx_i), .rb_data_o(rb_data_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .pc_i(pc_i),
    .br_valid_o(br_valid_o), .br_target_o(br_target_o),
    .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i), .stat_o(stat_o),
    .sv_rd_i(sv_rd_i), .sv_we_i(sv_we_i), .sv_wdata_i(sv_wdata_i),
    .sv_rdata_o(sv_rdata_o), .sv_err_o(sv_err_o),
    .exc_en_i(exc_en_i), .exc_mode_i(exc_mode_i), .exc_ret_i(exc_ret_i)
  );

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010, SVC = 5'b10011,
                         ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111;

  int tests = 0;
  int fails = 0;

  // Reference model: one plain array per kind of storage, keyed by mode set.
  logic [31:0] m_low [8];
  logic [31:0] m_mid_main [5];
  logic [31:0] m_mid_fast [5];
  logic [31:0] m_sp [6];
  logic [31:0] m_lr [6];
  logic [31:0] m_saved [6];
  logic [31:0] m_stat;
  logic        m_brv;
  logic [31:0] m_brt;

  function automatic bit legal(logic [4:0] m);
    return m inside {USR, FIQ, IRQ, SVC, ABT, UND, SYS};
  endfunction

  function automatic int set_of(logic [4:0] m);
    case (m)
      FIQ: return 1;
      IRQ: return 2;
      SVC: return 3;
      ABT: return 4;
      UND: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mread(logic [4:0] m, logic [3:0] idx);
    int s = set_of(m);
    if (idx == 4'd15) return pc_i + 32'd8;
    if (idx < 4'd8) return m_low[idx];
    if (idx < 4'd13) return (s == 1) ? m_mid_fast[idx - 8] : m_mid_main[idx - 8];
    if (idx == 4'd13) return m_sp[s];
    return m_lr[s];
  endfunction

  task automatic mwrite(logic [4:0] m, logic [3:0] idx, logic [31:0] d);
    int s = set_of(m);
    if (idx < 4'd8) m_low[idx] = d;
    else if (idx < 4'd13) begin
      if (s == 1) m_mid_fast[idx - 8] = d;
      else m_mid_main[idx - 8] = d;
    end
    else if (idx == 4'd13) m_sp[s] = d;
    else if (idx == 4'd14) m_lr[s] = d;
  endtask

  function automatic string lab(logic [3:0] idx);
    if (idx < 4'd8) return "R2";
    if (idx < 4'd13) return "R3";
    if (idx < 4'd15) return "R4";
    return "R5";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_low[i] = '0;
    for (int i = 0; i < 5; i++) begin m_mid_main[i] = '0; m_mid_fast[i] = '0; end
    for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_saved[i] = '0; end
    m_stat = 32'h0000_00D3;
    m_brv  = 1'b0;
    m_brt  = '0;
  endtask

  task automatic model_edge();
    logic [31:0] old_stat = m_stat;
    int s = set_of(mode_i);
    int e = set_of(exc_mode_i);
    m_brv = wr_en_i && wr_idx_i == 4'd15;
    if (m_brv) m_brt = wr_data_i;
    if (wr_en_i && wr_idx_i != 4'd15) mwrite(mode_i, wr_idx_i, wr_data_i);
    if (sv_we_i && s != 0) m_saved[s] = sv_wdata_i;
    if (stat_we_i) m_stat = stat_wdata_i;
    if (exc_en_i) begin
      m_lr[e] = exc_ret_i;
      if (e != 0) m_saved[e] = old_stat;
    end
  endtask

  // Compare every output with the model, then take one clock edge.
  task automatic step();
    int s;
    #1;
    s = set_of(mode_i);
    chk(lab(ra_idx_i), ra_data_o, mread(mode_i, ra_idx_i));
    chk(lab(rb_idx_i), rb_data_o, mread(mode_i, rb_idx_i));
    chk("R11", stat_o, m_stat);
    chk(s == 0 ? "R10" : "R9", sv_rdata_o, s == 0 ? 32'h0 : m_saved[s]);
    chk("R10", 32'(sv_err_o), 32'((sv_rd_i || sv_we_i) && s == 0));
    chk("R8", 32'(mode_err_o), 32'(!legal(mode_i)));
    chk("R6", 32'(br_valid_o), 32'(m_brv));
    if (m_brv) chk("R6", br_target_o, m_brt);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic quiet();
    wr_en_i = 0; stat_we_i = 0; sv_rd_i = 0; sv_we_i = 0; exc_en_i = 0;
  endtask

  task automatic wr(logic [4:0] m, logic [3:0] idx, logic [31:0] d);
    quiet(); mode_i = m; wr_en_i = 1; wr_idx_i = idx; wr_data_i = d;
    step();
    quiet();
  endtask

  task automatic rd_expect(string req, logic [4:0] m, logic [3:0] idx, logic [31:0] exp);
    quiet(); mode_i = m; ra_idx_i = idx; rb_idx_i = idx;
    #1;
    chk(req, ra_data_o, exp);
    chk(req, rb_data_o, exp);
    step();
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 0;

    // R1: reset state
    mode_i = USR;
    for (int i = 0; i < 15; i++) begin
      ra_idx_i = 4'(i); #1; chk("R1", ra_data_o, 32'h0);
    end
    chk("R1", stat_o, 32'h0000_00D3);
    chk("R1", 32'(br_valid_o), 32'h0);
    mode_i = SVC; sv_rd_i = 1; #1; chk("R1", sv_rdata_o, 32'h0);
    step();

    // R2: shared low registers
    wr(USR, 4'd3, 32'hA000_0003);
    rd_expect("R2", FIQ, 4'd3, 32'hA000_0003);
    rd_expect("R2", UND, 4'd3, 32'hA000_0003);

    // R3: fast-interrupt copy of 8..12
    wr(SVC, 4'd9, 32'hB000_0009);
    wr(FIQ, 4'd9, 32'hC000_0009);
    rd_expect("R3", IRQ, 4'd9, 32'hB000_0009);
    rd_expect("R3", FIQ, 4'd9, 32'hC000_0009);
    rd_expect("R3", SYS, 4'd9, 32'hB000_0009);

    // R4: six stack-pointer sets, user and system share one
    wr(USR, 4'd13, 32'h5000_0000);
    wr(FIQ, 4'd13, 32'h5000_0001);
    wr(IRQ, 4'd13, 32'h5000_0002);
    wr(SVC, 4'd13, 32'h5000_0003);
    wr(ABT, 4'd13, 32'h5000_0004);
    wr(UND, 4'd13, 32'h5000_0005);
    rd_expect("R4", SYS, 4'd13, 32'h5000_0000);
    rd_expect("R4", ABT, 4'd13, 32'h5000_0004);
    rd_expect("R4", FIQ, 4'd13, 32'h5000_0001);

    // R5: program counter read
    pc_i = 32'h0000_1000;
    rd_expect("R5", USR, 4'd15, 32'h0000_1008);

    // R6: write to 15 becomes a branch request
    wr(SVC, 4'd15, 32'h0000_4440);
    #1; chk("R6", 32'(br_valid_o), 32'h1); chk("R6", br_target_o, 32'h0000_4440);
    step();
    #1; chk("R6", 32'(br_valid_o), 32'h0);
    rd_expect("R6", SVC, 4'd15, 32'h0000_1008);

    // R7: read during write returns the old value, across a mode change
    quiet(); mode_i = IRQ; wr_en_i = 1; wr_idx_i = 4'd5; wr_data_i = 32'hE000_0005;
    ra_idx_i = 4'd5; rb_idx_i = 4'd5;
    #1; chk("R7", ra_data_o, 32'h0); chk("R7", rb_data_o, 32'h0);
    step();
    rd_expect("R7", ABT, 4'd5, 32'hE000_0005);

    // R8: illegal mode behaves as user
    rd_expect("R8", 5'b00000, 4'd13, 32'h5000_0000);
    quiet(); mode_i = 5'b10100; #1; chk("R8", 32'(mode_err_o), 32'h1); step();

    // R9: exception entry with a colliding link-register write
    quiet(); mode_i = USR; stat_we_i = 1; stat_wdata_i = 32'h6000_0010; step();
    quiet(); mode_i = IRQ; wr_en_i = 1; wr_idx_i = 4'd14; wr_data_i = 32'hDEAD_0000;
    exc_en_i = 1; exc_mode_i = IRQ; exc_ret_i = 32'h0000_2004;
    stat_we_i = 1; stat_wdata_i = 32'h6000_0092;
    step();
    rd_expect("R9", IRQ, 4'd14, 32'h0000_2004);
    quiet(); mode_i = IRQ; sv_rd_i = 1; #1; chk("R9", sv_rdata_o, 32'h6000_0010);
    chk("R11", stat_o, 32'h6000_0092); step();
    // R9: saved-slot store wins over a saved-status write to the same slot
    quiet(); mode_i = IRQ; sv_we_i = 1; sv_wdata_i = 32'h1111_1111;
    exc_en_i = 1; exc_mode_i = IRQ; exc_ret_i = 32'h0000_3000; step();
    quiet(); mode_i = IRQ; sv_rd_i = 1; #1; chk("R9", sv_rdata_o, 32'h6000_0092); step();

    // R10: saved-status access without a saved slot
    quiet(); mode_i = SVC; sv_we_i = 1; sv_wdata_i = 32'h7777_0003; step();
    quiet(); mode_i = USR; sv_rd_i = 1; #1; chk("R10", 32'(sv_err_o), 32'h1);
    chk("R10", sv_rdata_o, 32'h0); step();
    quiet(); mode_i = SYS; sv_we_i = 1; sv_wdata_i = 32'h9999_9999; #1;
    chk("R10", 32'(sv_err_o), 32'h1); step();
    quiet(); mode_i = 5'b01010; sv_we_i = 1; sv_wdata_i = 32'h8888_8888; step();
    quiet(); mode_i = SVC; sv_rd_i = 1; #1; chk("R10", sv_rdata_o, 32'h7777_0003); step();

    // Mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [4:0] modes [7] = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS};
      quiet();
      mode_i     = ($urandom_range(15) == 0) ? 5'($urandom) : modes[$urandom_range(6)];
      ra_idx_i   = 4'($urandom);
      rb_idx_i   = 4'($urandom);
      wr_en_i    = $urandom_range(1);
      wr_idx_i   = 4'($urandom);
      wr_data_i  = $urandom;
      pc_i       = $urandom & 32'hFFFF_FFFC;
      stat_we_i  = ($urandom_range(7) == 0);
      stat_wdata_i = $urandom;
      sv_rd_i    = $urandom_range(1);
      sv_we_i    = ($urandom_range(5) == 0);
      sv_wdata_i = $urandom;
      exc_en_i   = ($urandom_range(7) == 0);
      exc_mode_i = ($urandom_range(9) == 0) ? 5'($urandom) : modes[$urandom_range(6)];
      exc_ret_i  = $urandom;
      step();
    end

    quiet();
    step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule